// File: doc/BRIEF.md
# Automatic Standard Select Controller

This block lets a serial video receiver find the data-rate standard of an incoming signal with no outside help. It watches the horizontal sync pulses that the framer produces. When no sync has arrived for a programmable number of slow oscillator ticks, it raises a sync warning. While that warning is up, each oscillator tick moves a 2-bit standard select code to the next of four candidates. The code is driven out on two pins that steer the rate-dependent front end.

A single sync pulse clears the warning and restarts the timeout, so the search stops on the standard that produced it. The warning needs a full timeout to come back up but one sync to go away. This hysteresis takes the place of an analog integrator followed by a Schmitt trigger. The slow analog oscillator is represented by a one-cycle tick enable input.

A manual override loads a supplied code and freezes automatic stepping for as long as it is held. When it is released, the search continues from the loaded value.

Top module: `std_select_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, the select code is 00 (ss1_o=0, ss0_o=0) and warn_o is 1.
- R2: ss0_o carries bit 0 and ss1_o carries bit 1 of the select code. For example, code 2 gives ss1_o=1 and ss0_o=0.
- R3: After warn_o clears, warn_o rises in the cycle after the TIMEOUT_TICKS-th osc_tick_i that arrives with no hsync_i. The tick that raises the warning does not step the code.
- R4: One hsync_i pulse clears warn_o in the next cycle and restarts the tick count from zero, whatever count had built up. The code keeps its value.
- R5: While warn_o is 1 and override is off, each osc_tick_i cycle without hsync_i advances the code by exactly one in the next cycle, and 3 wraps to 0.
- R6: The code does not change in any cycle without a tick, or while warn_o is 0, unless override is on.
- R7: When hsync_i and osc_tick_i arrive in the same cycle, the sync wins: warn_o clears and the code does not step.
- R8: While ovr_en_i is 1, the code takes the value of ovr_code_i in the next cycle and ticks do not step it. After release, stepping resumes from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | One-cycle horizontal sync pulse from the framer |
| osc_tick_i | input | 1 | One-cycle enable from the slow search oscillator |
| ovr_en_i | input | 1 | Manual override enable |
| ovr_code_i | input | 2 | Code forced while override is on |
| ss0_o | output | 1 | Select code bit 0 |
| ss1_o | output | 1 | Select code bit 1 |
| warn_o | output | 1 | Sync warning flag |

## Verification
A tick counter that starts from the wrong value, or that is not cleared by sync, moves the rise of warn_o earlier or later than the TIMEOUT_TICKS-th tick. The bench sees this on the tick where the flag should rise, or on the one before it. A wrong step condition shows up one cycle after the offending tick, as an ss1_o/ss0_o pair that moves when it should hold, moves by more than one, or fails to wrap. Wrong priority between sync and tick, or between override and stepping, shows in the next cycle on warn_o or on the code.

// File: rtl/std_sel_pkg.sv
package std_sel_pkg;

  localparam int unsigned CODE_W = 2;

  typedef logic [CODE_W-1:0] std_code_t;

  // Next candidate standard, wrapping from the last to the first.
  function automatic std_code_t next_std(input std_code_t cur);
    return std_code_t'(cur + 1'b1);
  endfunction

  // True when the tick about to be counted completes the timeout window.
  function automatic logic window_done(input int unsigned count_now,
                                       input int unsigned limit);
    return (count_now + 1) >= limit;
  endfunction

endpackage

// File: rtl/sync_watchdog.sv
module sync_watchdog
  import std_sel_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  input  logic tick_i,
  output logic warn_o,
  output logic timeout_ev_o
);

  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

  logic [CNT_W-1:0] tick_cnt_q;
  logic             warn_q;
  logic             count_ev;

  // A tick is counted only while the flag is down and no sync clears it.
  assign count_ev     = tick_i && !warn_q && !hsync_i;
  assign timeout_ev_o = count_ev && window_done(int'(tick_cnt_q), TIMEOUT_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt_q <= '0;
      warn_q     <= 1'b1;
    end else if (hsync_i) begin
      tick_cnt_q <= '0;
      warn_q     <= 1'b0;
    end else if (timeout_ev_o) begin
      tick_cnt_q <= '0;
      warn_q     <= 1'b1;
    end else if (count_ev) begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end

  assign warn_o = warn_q;

  // R4: a sync always clears the flag one cycle later
  assert_sync_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i |=> !warn_o);

  // R3: without a tick and without a sync, the flag cannot move
  assert_warn_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_i && !tick_i) |=> $stable(warn_o));

  // R3: the count stays inside the window
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tick_cnt_q) < int'(TIMEOUT_TICKS));

  // R3: once raised, the flag stays up until a sync arrives
  assert_warn_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_o && !hsync_i) |=> warn_o);

endmodule

// File: rtl/std_stepper.sv
module std_stepper
  import std_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      load_i,
  input  std_code_t load_val_i,
  output std_code_t code_o
);

  std_code_t code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load_i) begin
      code_q <= load_val_i;
    end else if (step_i) begin
      code_q <= next_std(code_q);
    end
  end

  assign code_o = code_q;

  // R8: a load takes the supplied value
  assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (code_o == $past(load_val_i)));

  // R5: one step moves the code by exactly one, modulo four
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (code_o == std_code_t'($past(code_o) + 2'd1)));

  // R6: without a step or a load, the code holds
  assert_code_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(code_o));

endmodule

// File: rtl/std_select_ctrl.sv
module std_select_ctrl
  import std_sel_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_i,
  input  logic       osc_tick_i,
  input  logic       ovr_en_i,
  input  logic [1:0] ovr_code_i,
  output logic       ss0_o,
  output logic       ss1_o,
  output logic       warn_o
);

  logic      warn;
  logic      timeout_ev;
  logic      step_ev;
  std_code_t code;

  sync_watchdog #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_i     (hsync_i),
    .tick_i      (osc_tick_i),
    .warn_o      (warn),
    .timeout_ev_o(timeout_ev)
  );

  // Search step: flag up, a tick, no sync in the same cycle, no override.
  assign step_ev = warn && osc_tick_i && !hsync_i && !ovr_en_i;

  std_stepper u_stepper (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_ev),
    .load_i    (ovr_en_i),
    .load_val_i(std_code_t'(ovr_code_i)),
    .code_o    (code)
  );

  assign ss0_o  = code[0];
  assign ss1_o  = code[1];
  assign warn_o = warn;

  // R7: a sync in the same cycle as a tick leaves the code unchanged
  assert_sync_beats_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_i && osc_tick_i && !ovr_en_i) |=> ($stable(ss0_o) && $stable(ss1_o)));

  // R3: the tick that raises the flag does not step the code
  assert_timeout_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_ev && !ovr_en_i) |=> ($stable(ss0_o) && $stable(ss1_o) && warn_o));

  // R6: while the flag is down, the code holds unless override is on
  assert_no_step_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!warn_o && !ovr_en_i) |=> ($stable(ss0_o) && $stable(ss1_o)));

endmodule

// File: tb/std_select_ctrl_tb.sv
module std_select_ctrl_tb;

  localparam int unsigned TMO = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync_i;
  logic       osc_tick_i;
  logic       ovr_en_i;
  logic [1:0] ovr_code_i;
  logic       ss0_o;
  logic       ss1_o;
  logic       warn_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  std_select_ctrl #(.TIMEOUT_TICKS(TMO)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_i   (hsync_i),
    .osc_tick_i(osc_tick_i),
    .ovr_en_i  (ovr_en_i),
    .ovr_code_i(ovr_code_i),
    .ss0_o     (ss0_o),
    .ss1_o     (ss1_o),
    .warn_o    (warn_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code_now();
    return {30'd0, ss1_o, ss0_o};
  endfunction

  // Every helper drives at a negedge and leaves the caller at the next negedge.
  task automatic pulse(input bit tk, input bit hs);
    osc_tick_i = tk;
    hsync_i    = hs;
    @(negedge clk);
    osc_tick_i = 1'b0;
    hsync_i    = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hsync_i = 1'b0; osc_tick_i = 1'b0;
    ovr_en_i = 1'b0; ovr_code_i = 2'd0;
    idle(3);
    check("R1 code in reset", code_now(), 0);
    check("R1 warn in reset", int'(warn_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after reset", code_now(), 0);
    check("R1 warn after reset", int'(warn_o), 1);
  endtask

  task automatic t_wrap();
    for (int i = 1; i <= 4; i++) begin
      pulse(1'b1, 1'b0);
      check("R5 step per tick", code_now(), i % 4);
    end
  endtask

  task automatic t_idle_hold();
    pulse(1'b1, 1'b0);
    idle(20);
    check("R6 no tick holds code", code_now(), 1);
  endtask

  task automatic t_sync_clear();
    pulse(1'b0, 1'b1);
    check("R4 sync clears warn", int'(warn_o), 0);
    check("R4 sync keeps code", code_now(), 1);
  endtask

  task automatic t_timeout();
    for (int i = 0; i < TMO - 1; i++) pulse(1'b1, 1'b0);
    check("R3 warn low before window ends", int'(warn_o), 0);
    check("R6 ticks with warn low keep code", code_now(), 1);
    pulse(1'b1, 1'b0);
    check("R3 warn rises on last tick", int'(warn_o), 1);
    check("R3 raising tick does not step", code_now(), 1);
    pulse(1'b1, 1'b0);
    check("R5 step after warn", code_now(), 2);
  endtask

  task automatic t_restart();
    pulse(1'b0, 1'b1);
    for (int i = 0; i < TMO - 1; i++) pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    for (int i = 0; i < TMO - 1; i++) pulse(1'b1, 1'b0);
    check("R4 sync restarts count", int'(warn_o), 0);
    check("R4 code kept across syncs", code_now(), 2);
  endtask

  task automatic t_collide();
    pulse(1'b1, 1'b0);
    check("R3 warn up before collision", int'(warn_o), 1);
    pulse(1'b1, 1'b1);
    check("R7 sync wins over tick warn", int'(warn_o), 0);
    check("R7 sync wins over tick code", code_now(), 2);
  endtask

  task automatic t_override();
    for (int i = 0; i < TMO; i++) pulse(1'b1, 1'b0);
    check("R3 warn up before override", int'(warn_o), 1);
    ovr_en_i = 1'b1; ovr_code_i = 2'd1;
    @(negedge clk);
    check("R8 override loads", code_now(), 1);
    ovr_code_i = 2'd2;
    @(negedge clk);
    check("R2 ss1 is bit 1", int'(ss1_o), 1);
    check("R2 ss0 is bit 0", int'(ss0_o), 0);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    check("R8 ticks frozen under override", code_now(), 2);
    ovr_en_i = 1'b0;
    @(negedge clk);
    check("R8 release keeps value", code_now(), 2);
    pulse(1'b1, 1'b0);
    check("R8 stepping resumes", code_now(), 3);
    pulse(1'b1, 1'b0);
    check("R5 wrap 3 to 0", code_now(), 0);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_idle_hold();
    t_sync_clear();
    t_timeout();
    t_restart();
    t_collide();
    t_override();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule